// File: doc/BRIEF.md
# Firmware-Update Control Register with Unlock Gate

This block guards the system-control register that a small microcontroller uses to prepare an in-field firmware rewrite. The register cannot be changed until software writes two fixed key bytes, back to back, into a separate key register. Once the register is open, software can enable the auxiliary RAM, choose which code bank holds the loader, and arm programming. The block also requests a software reset.

When programming is armed, the next interrupt that wakes the CPU from idle clears the program counter and moves execution to the chosen bank. As a result, the first interrupt return lands at address 00h of that bank. The block also samples strap pins after every hardware reset. If they call for it, the device is forced to boot from the loader bank. In that case the control register's top bit reads 1 and the software reset is refused.

A hardware reset has two sources: the asynchronous power-on reset, and an external reset pin that is accepted only after it has stayed high for `HOLD_CYC` consecutive clocks.

Top module: `isp_ctrl_unit`

## Requirements
- R1: After reset the control register reads 00h, `loader_sel_o`, `aux_ram_en_o`, `soft_rst_o` and `pc_clear_o` are 0, and the key gate is locked. This holds when the strap pins do not request a forced boot.
- R2: A write to `CTL_ADDR` changes nothing unless the gate is open. The gate opens when the key register (`KEY_ADDR`) receives `KEY_A` (87h) and then `KEY_B` (59h) as two consecutive key-register writes. Writes to other addresses in between do not matter.
- R3: Writing any other value to the key register locks the gate. Writing `KEY_B` when it does not directly follow `KEY_A` leaves the gate locked. Writing `KEY_A` restarts the sequence from any state.
- R4: Control register fields are: bit 0 arms programming, bit 1 selects the loader bank (1 = loader bank), and bit 4 enables the auxiliary RAM. These three bits are stored. Bits 6, 5, 3 and 2 always read 0. Bit 7 reads the forced-boot flag and is never stored.
- R5: When bit 0 is set and `idle_i` and `wake_irq_i` are both high at a clock edge, `pc_clear_o` pulses for one cycle after that edge and `loader_sel_o` takes the value of bit 1. Nothing happens if bit 0 is clear or `idle_i` is low.
- R6: An open-gate write with bits 7, 1 and 0 all set, outside forced boot, is a software reset. `soft_rst_o` pulses for one cycle after the write edge, the register reads 00h, `loader_sel_o` goes to 0, and the gate locks.
- R7: At the first clock after a hardware reset the strap pins are sampled. The boot is forced when `boot_pin_a_i` is 0, or when both bits of `boot_pin_b_i` are 0. In forced boot, bit 7 reads 1, `loader_sel_o` is 1, and a software-reset write raises no pulse and leaves the bank alone; its bits 4, 1 and 0 are still stored.
- R8: `ext_rst_i` held high for `HOLD_CYC` consecutive clock edges acts as a hardware reset: all state is cleared and the strap pins are sampled again. A pulse one edge shorter has no effect.
- R9: A software reset does not sample the strap pins again. The forced-boot flag stays 0 even if the pins now request a forced boot.
- R10: `aux_ram_en_o` follows stored bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | External reset request, qualified by hold time |
| sfr_we_i | input | 1 | Special-register write strobe |
| sfr_addr_i | input | AW | Special-register address (write and read) |
| sfr_wdata_i | input | DW | Write data |
| sfr_rdata_o | output | DW | Read data: control register at `CTL_ADDR`, else 0 |
| idle_i | input | 1 | CPU is in idle mode |
| wake_irq_i | input | 1 | Interrupt wake event |
| boot_pin_a_i | input | 1 | Strap pin; low forces loader boot |
| boot_pin_b_i | input | 2 | Strap pin pair; both low forces loader boot |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| pc_clear_o | output | 1 | One-cycle program-counter clear request |
| loader_sel_o | output | 1 | Active code bank: 1 = loader bank |
| aux_ram_en_o | output | 1 | Auxiliary RAM enable |

## Verification
The hardest state to reach from the ports is forced boot combined with an open gate and a software-reset write. The stimulus needs a reset with the strap pins low, then the full key sequence, then a write with bits 7, 1 and 0 set. The bench builds this case directly. It then applies external reset pulses of `HOLD_CYC-1` and `HOLD_CYC` edges to show the exact qualification boundary and the return to the main bank. A seeded random phase then mixes key bytes, control writes, foreign-address writes and wake events with and without idle. This exercises key sequences that are interrupted or restarted, and software resets landing at arbitrary points.

// File: rtl/isp_ctrl_pkg.sv
package isp_ctrl_pkg;
  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam int BIT_SWR  = 7;
  localparam int BIT_AUX  = 4;
  localparam int BIT_BSEL = 1;
  localparam int BIT_PEN  = 0;

  function automatic logic boot_force(input logic pin_a, input logic [1:0] pin_b);
    return !pin_a || (pin_b == 2'b00);
  endfunction
endpackage

// File: rtl/isp_rst_qual.sv
module isp_rst_qual #(
  parameter int HOLD_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  output logic hw_rst_o
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign hw_rst_o = ext_rst_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!ext_rst_i)    cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assert_qual_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_o |-> (ext_rst_i && $past(ext_rst_i)));
endmodule

// File: rtl/isp_key_fsm.sv
module isp_key_fsm
  import isp_ctrl_pkg::*;
#(
  parameter int             DW    = 8,
  parameter logic [DW-1:0]  KEY_A = 8'h87,
  parameter logic [DW-1:0]  KEY_B = 8'h59
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          key_we_i,
  input  logic [DW-1:0] key_data_i,
  output logic          unlocked_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_we_i) begin
      if (key_data_i == KEY_A)                          st_d = KEY_HALF;
      else if (key_data_i == KEY_B && st_q == KEY_HALF) st_d = KEY_OPEN;
      else                                              st_d = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= KEY_LOCKED;
    else if (clr_i) st_q <= KEY_LOCKED;
    else            st_q <= st_d;
  end

  assign unlocked_o = (st_q == KEY_OPEN);

  assert_open_after_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && !$past(unlocked_o)) |-> $past(key_we_i && key_data_i == KEY_B));

  assert_bad_key_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_data_i != KEY_A && key_data_i != KEY_B) |=> !unlocked_o);
endmodule

// File: rtl/isp_ctl_core.sv
module isp_ctl_core
  import isp_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_rst_i,
  input  logic          ctl_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          idle_i,
  input  logic          wake_irq_i,
  input  logic          pin_a_i,
  input  logic [1:0]    pin_b_i,
  output logic          swr_req_o,
  output logic [DW-1:0] ctl_rd_o,
  output logic          soft_rst_o,
  output logic          pc_clear_o,
  output logic          loader_sel_o,
  output logic          aux_ram_en_o
);
  logic pend_q, forced_q, aux_q, bsel_q, pen_q, bank_q, soft_q, pcclr_q;
  logic wr_ok, swr_hit, wake_hit;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[6:5], wdata_i[3:2]};

  assign wr_ok    = ctl_we_i && !pend_q;
  assign swr_hit  = wr_ok && wdata_i[BIT_SWR] && wdata_i[BIT_BSEL] && wdata_i[BIT_PEN] && !forced_q;
  assign wake_hit = !pend_q && pen_q && idle_i && wake_irq_i;
  assign swr_req_o = swr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1; forced_q <= 1'b0; aux_q <= 1'b0; bsel_q <= 1'b0;
      pen_q  <= 1'b0; bank_q   <= 1'b0; soft_q <= 1'b0; pcclr_q <= 1'b0;
    end else if (hw_rst_i) begin
      pend_q <= 1'b1; forced_q <= 1'b0; aux_q <= 1'b0; bsel_q <= 1'b0;
      pen_q  <= 1'b0; bank_q   <= 1'b0; soft_q <= 1'b0; pcclr_q <= 1'b0;
    end else if (pend_q) begin
      // strap sample on first clock out of hardware reset
      pend_q   <= 1'b0;
      forced_q <= boot_force(pin_a_i, pin_b_i);
      bank_q   <= boot_force(pin_a_i, pin_b_i);
    end else begin
      soft_q  <= swr_hit;
      pcclr_q <= wake_hit && !swr_hit;
      if (swr_hit) begin
        aux_q <= 1'b0; bsel_q <= 1'b0; pen_q <= 1'b0; bank_q <= 1'b0;
      end else begin
        if (wr_ok) begin
          aux_q  <= wdata_i[BIT_AUX];
          bsel_q <= wdata_i[BIT_BSEL];
          pen_q  <= wdata_i[BIT_PEN];
        end
        if (wake_hit) bank_q <= bsel_q;
      end
    end
  end

  always_comb begin
    ctl_rd_o           = '0;
    ctl_rd_o[BIT_SWR]  = forced_q;
    ctl_rd_o[BIT_AUX]  = aux_q;
    ctl_rd_o[BIT_BSEL] = bsel_q;
    ctl_rd_o[BIT_PEN]  = pen_q;
  end

  assign soft_rst_o   = soft_q;
  assign pc_clear_o   = pcclr_q;
  assign loader_sel_o = bank_q;
  assign aux_ram_en_o = aux_q;

  assert_wake_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_clear_o |-> $past(idle_i && wake_irq_i));

  assert_soft_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  assert_soft_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (!loader_sel_o && ctl_rd_o == '0));

  assert_forced_no_soft_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rd_o[BIT_SWR] |-> !soft_rst_o);
endmodule

// File: rtl/isp_ctrl_unit.sv
module isp_ctrl_unit #(
  parameter int            DW       = 8,
  parameter int            AW       = 8,
  parameter logic [DW-1:0] KEY_A    = 8'h87,
  parameter logic [DW-1:0] KEY_B    = 8'h59,
  parameter logic [AW-1:0] KEY_ADDR = 8'hF6,
  parameter logic [AW-1:0] CTL_ADDR = 8'hBF,
  parameter int            HOLD_CYC = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_rst_i,
  input  logic          sfr_we_i,
  input  logic [AW-1:0] sfr_addr_i,
  input  logic [DW-1:0] sfr_wdata_i,
  output logic [DW-1:0] sfr_rdata_o,
  input  logic          idle_i,
  input  logic          wake_irq_i,
  input  logic          boot_pin_a_i,
  input  logic [1:0]    boot_pin_b_i,
  output logic          soft_rst_o,
  output logic          pc_clear_o,
  output logic          loader_sel_o,
  output logic          aux_ram_en_o
);
  logic hw_rst, unlocked, swr_req, key_we, ctl_we;
  logic [DW-1:0] ctl_rd;

  assign key_we = sfr_we_i && (sfr_addr_i == KEY_ADDR);
  assign ctl_we = sfr_we_i && (sfr_addr_i == CTL_ADDR) && unlocked;

  isp_rst_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_i(ext_rst_i), .hw_rst_o(hw_rst)
  );

  isp_key_fsm #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hw_rst || swr_req),
    .key_we_i(key_we), .key_data_i(sfr_wdata_i), .unlocked_o(unlocked)
  );

  isp_ctl_core #(.DW(DW)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_rst_i(hw_rst), .ctl_we_i(ctl_we),
    .wdata_i(sfr_wdata_i), .idle_i(idle_i), .wake_irq_i(wake_irq_i),
    .pin_a_i(boot_pin_a_i), .pin_b_i(boot_pin_b_i), .swr_req_o(swr_req),
    .ctl_rd_o(ctl_rd), .soft_rst_o(soft_rst_o), .pc_clear_o(pc_clear_o),
    .loader_sel_o(loader_sel_o), .aux_ram_en_o(aux_ram_en_o)
  );

  assign sfr_rdata_o = (sfr_addr_i == CTL_ADDR) ? ctl_rd : '0;

  assert_locked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_i && sfr_addr_i == CTL_ADDR && !unlocked && !hw_rst)
      |=> (aux_ram_en_o == $past(aux_ram_en_o)));
endmodule

// File: tb/isp_ctrl_unit_tb_top.sv
module isp_ctrl_unit_tb_top;
  localparam logic [7:0] KA = 8'h87, KB = 8'h59, KADR = 8'hF6, CADR = 8'hBF, OADR = 8'h80;
  localparam int HOLD = 24;

  logic clk = 1'b0, rst_n = 1'b0, ext_rst = 1'b0, we = 1'b0;
  logic [7:0] addr = CADR, wdata = '0, rdata;
  logic idle = 1'b0, wake = 1'b0, pin_a = 1'b1;
  logic [1:0] pin_b = 2'b11;
  logic soft_rst, pc_clear, loader_sel, aux_en;

  int total = 0, bad = 0;
  int m_state = 0;
  logic m_aux = 0, m_bs = 0, m_pe = 0, m_forced = 0, m_bank = 0;

  always #10 clk = ~clk;

  isp_ctrl_unit #(.HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_i(ext_rst), .sfr_we_i(we),
    .sfr_addr_i(addr), .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
    .idle_i(idle), .wake_irq_i(wake), .boot_pin_a_i(pin_a), .boot_pin_b_i(pin_b),
    .soft_rst_o(soft_rst), .pc_clear_o(pc_clear), .loader_sel_o(loader_sel),
    .aux_ram_en_o(aux_en)
  );

  function automatic logic [7:0] exp_rd();
    return {m_forced, 2'b00, m_aux, 2'b00, m_bs, m_pe};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_hw_reset();
    m_state = 0; m_aux = 0; m_bs = 0; m_pe = 0;
    m_forced = !pin_a || (pin_b == 2'b00);
    m_bank = m_forced;
  endtask

  task automatic check_state(input string req);
    addr = CADR;
    #1;
    chk(req, rdata, exp_rd());
    chk(req, {7'd0, loader_sel}, {7'd0, m_bank});
    chk(req, {7'd0, aux_en}, {7'd0, m_aux});
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    logic exp_soft;
    exp_soft = 1'b0;
    if (a == KADR) begin
      if (d == KA) m_state = 1;
      else if (d == KB && m_state == 1) m_state = 2;
      else m_state = 0;
    end else if (a == CADR && m_state == 2) begin
      if (d[7] && d[1] && d[0] && !m_forced) begin
        exp_soft = 1'b1;
        m_aux = 0; m_bs = 0; m_pe = 0; m_bank = 0; m_state = 0;
      end else begin
        m_aux = d[4]; m_bs = d[1]; m_pe = d[0];
      end
    end
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    chk("R6 soft pulse", {7'd0, soft_rst}, {7'd0, exp_soft});
    chk("R5 no pc clear on write", {7'd0, pc_clear}, 8'd0);
  endtask

  task automatic unlock();
    sfr_wr(KADR, KA);
    sfr_wr(KADR, KB);
  endtask

  task automatic wake_ev(input logic idl);
    logic exp_pc;
    exp_pc = m_pe && idl;
    idle = idl; wake = 1'b1;
    @(posedge clk); @(negedge clk);
    idle = 1'b0; wake = 1'b0;
    if (exp_pc) m_bank = m_bs;
    chk("R5 pc clear", {7'd0, pc_clear}, {7'd0, exp_pc});
    check_state("R5 bank after wake");
  endtask

  task automatic por(input logic pa, input logic [1:0] pb);
    pin_a = pa; pin_b = pb;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    model_hw_reset();
  endtask

  task automatic ext_pulse(input int n, input logic pa, input logic [1:0] pb);
    pin_a = pa; pin_b = pb;
    ext_rst = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); ext_rst = 1'b0;
    @(posedge clk); @(negedge clk);
    if (n >= HOLD) model_hw_reset();
    check_state("R8 ext reset");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    por(1'b1, 2'b11);
    check_state("R1 reset state");
    chk("R1 soft idle", {6'd0, soft_rst, pc_clear}, 8'd0);

    sfr_wr(CADR, 8'h13); check_state("R2 locked write ignored");
    sfr_wr(KADR, KB); sfr_wr(CADR, 8'h13); check_state("R3 lone second key");
    sfr_wr(KADR, KA); sfr_wr(KADR, 8'h00); sfr_wr(KADR, KB);
    sfr_wr(CADR, 8'h13); check_state("R3 broken sequence");
    sfr_wr(KADR, KA); sfr_wr(OADR, 8'h55); sfr_wr(KADR, KB);
    sfr_wr(CADR, 8'h13); check_state("R2 foreign write between keys");
    chk("R10 aux enable", {7'd0, aux_en}, 8'd1);
    sfr_wr(CADR, 8'h7C); check_state("R4 reserved bits read zero");
    sfr_wr(KADR, 8'h33); sfr_wr(CADR, 8'h13); check_state("R3 bad key closes");

    unlock(); sfr_wr(CADR, 8'h03);
    wake_ev(1'b0);
    wake_ev(1'b1);
    chk("R5 loader bank", {7'd0, loader_sel}, 8'd1);
    sfr_wr(CADR, 8'h01); wake_ev(1'b1);
    chk("R5 bsel zero bank", {7'd0, loader_sel}, 8'd0);
    sfr_wr(CADR, 8'h00); wake_ev(1'b1);

    sfr_wr(CADR, 8'h83); check_state("R6 soft reset");
    sfr_wr(CADR, 8'h13); check_state("R6 locked after soft reset");

    por(1'b0, 2'b11); check_state("R7 pin a forced");
    por(1'b1, 2'b01); check_state("R7 one b pin low not forced");
    por(1'b1, 2'b00); check_state("R7 both b pins forced");
    chk("R7 bit7", rdata, 8'h80);
    unlock(); sfr_wr(CADR, 8'h83); check_state("R7 soft reset refused");

    ext_pulse(HOLD - 1, 1'b1, 2'b11);
    ext_pulse(HOLD, 1'b1, 2'b11);
    chk("R8 main bank", {7'd0, loader_sel}, 8'd0);

    pin_a = 1'b0; pin_b = 2'b00;
    unlock(); sfr_wr(CADR, 8'h93); check_state("R9 no pin resample");
    pin_a = 1'b1; pin_b = 2'b11;

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: sfr_wr(KADR, KA);
        1: sfr_wr(KADR, KB);
        2: sfr_wr(KADR, 8'($urandom));
        3: sfr_wr(CADR, ($urandom_range(0, 3) == 0) ? 8'h83 : 8'($urandom));
        4: wake_ev(1'($urandom));
        default: sfr_wr(OADR, 8'($urandom));
      endcase
      check_state("R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule